// File: doc/BRIEF.md
# Walsh Coefficient Response Compactor

This block shortens the one-bit response of a circuit under test into two signed signatures. Each signature is a Walsh coefficient count. On every applied vector the block compares the response bit with a reference bit, and it works out that reference from the same input vector that drives the circuit under test. When the two bits agree, the signature counter steps up by one. When they disagree, it steps down by one. At the end of a run, each signature therefore holds the number of agreements minus the number of disagreements.

There are two references. The first is the zeroth-order Walsh function, which is a constant 1, so its signature is a syndrome count: ones in the response minus zeros. The second is the highest-order Walsh function, which follows the parity of the zeros in the input vector.

A pattern source drives the input vector with a valid strobe. A run enable starts and stops the accumulation. The two signatures stay readable and do not change while the block is stopped. Comparing them with golden values is left to the surrounding logic.

Top module: `walsh_sig_compactor`

## Requirements
- R1: A low `rst_n` at a clock edge is a synchronous reset. It sets both signatures to 0 at that edge, whatever `run` and `vec_valid` are doing.
- R2: At an edge where `run` or `vec_valid` is 0, neither signature changes, whatever `vec` and `dut_out` are.
- R3: The DC signature `sig_dc` moves +1 at an updating edge with `dut_out` = 1, and −1 at an updating edge with `dut_out` = 0.
- R4: The parity reference bit is 1 when `vec` has an even number of 0 bits (including none), and 0 when that number is odd. `sig_par` moves +1 when `dut_out` equals this bit and −1 when it does not.
- R5: A signature at its most positive value (2^(SIG_W−1)−1) stays there on a further +1 step and never wraps to negative.
- R6: A signature at its most negative value (−2^(SIG_W−1)) stays there on a further −1 step. The other signature keeps updating on its own.
- R7: Each signature changes by at most one count per clock edge.
- R8: An update shows on the outputs right after the clock edge that samples the vector, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start/stop enable; 1 accumulates |
| vec_valid | input | 1 | Applied vector is valid this cycle |
| vec | input | VEC_W | Input vector applied to the circuit under test |
| dut_out | input | 1 | Response bit of the circuit under test |
| sig_dc | output | SIG_W | Signed signature against the constant Walsh function |
| sig_par | output | SIG_W | Signed signature against the parity Walsh function |

## Verification
A new count is due one clock after the edge that samples a valid vector. Each signature has exactly one register between the input ports and its output. The bench drives every input on the falling edge and reads both signatures on the next falling edge, which falls halfway between the sampling edge and the edge after it. One directed case reads the outputs just before the sampling edge to show that they are still unchanged, then reads them again half a cycle after that edge. The bench runs at a 5-bit signature width, so that both saturation limits are reached in a few dozen cycles.

// File: rtl/walsh_pkg.sv
// Shared definitions for the Walsh response compactor.
// Assumes: signature index 0 is the DC function, index 1 the parity function.
package walsh_pkg;
    typedef enum int {
        FN_DC  = 0,
        FN_PAR = 1
    } walsh_fn_e;

    localparam int NUM_FN = 2;
endpackage

// File: rtl/walsh_ref.sv
// Reference bit generator: for each Walsh function tracked, produces the
// expected response bit for the current vector.
// Assumes: vec is stable while it is sampled; purely combinational.
module walsh_ref
    import walsh_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0]  vec,
    output logic [NUM_FN-1:0] ref_bits
);
    logic zeros_odd;

    // Parity of the count of zero bits in the vector.
    always_comb zeros_odd = ^(~vec);

    // Select each reference function by its index.
    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        if (g == FN_DC) begin : g_dc
            assign ref_bits[g] = 1'b1;
        end else begin : g_par
            assign ref_bits[g] = ~zeros_odd;
        end
    end
endmodule

// File: rtl/sat_updown.sv
// Signed saturating up/down counter, one step per enabled clock.
// Assumes: synchronous active-low reset; holds at either limit.
module sat_updown #(
    parameter int SIG_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    up,
    output logic signed [SIG_W-1:0] cnt
);
    localparam logic signed [SIG_W-1:0] MAX_V = {1'b0, {(SIG_W-1){1'b1}}};
    localparam logic signed [SIG_W-1:0] MIN_V = {1'b1, {(SIG_W-1){1'b0}}};
    localparam logic signed [SIG_W-1:0] ONE_V = {{(SIG_W-1){1'b0}}, 1'b1};

    // Count register: clear, step towards the requested direction, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            if (up && cnt != MAX_V) begin
                cnt <= cnt + ONE_V;
            end else if (!up && cnt != MIN_V) begin
                cnt <= cnt - ONE_V;
            end
        end
    end
endmodule

// File: rtl/walsh_sig_compactor.sv
// Walsh coefficient response compactor: one compare-and-update per valid,
// enabled cycle against the DC and parity Walsh functions of the vector.
// Assumes: vec and dut_out belong to the same applied pattern in a cycle.
module walsh_sig_compactor
    import walsh_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int SIG_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    vec_valid,
    input  logic [VEC_W-1:0]        vec,
    input  logic                    dut_out,
    output logic signed [SIG_W-1:0] sig_dc,
    output logic signed [SIG_W-1:0] sig_par
);
    logic [NUM_FN-1:0]       ref_bits;
    logic [NUM_FN-1:0]       agree;
    logic                    upd;
    logic signed [SIG_W-1:0] sig [NUM_FN];

    walsh_ref #(.VEC_W(VEC_W)) u_ref (
        .vec      (vec),
        .ref_bits (ref_bits)
    );

    // An update happens only on a valid vector while running.
    always_comb upd = run & vec_valid;

    // One agreement detector and counter per Walsh function.
    for (genvar g = 0; g < NUM_FN; g++) begin : g_sig
        assign agree[g] = ~(dut_out ^ ref_bits[g]);
        sat_updown #(.SIG_W(SIG_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (upd),
            .up    (agree[g]),
            .cnt   (sig[g])
        );
    end

    // Map counters to named outputs.
    always_comb begin
        sig_dc  = sig[FN_DC];
        sig_par = sig[FN_PAR];
    end
endmodule

// File: rtl/walsh_sig_compactor_chk.sv
// Property checker for walsh_sig_compactor; attached by bind below.
// Assumes: synchronous active-low reset on the checked block.
module walsh_sig_compactor_chk #(
    parameter int SIG_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input logic                    vec_valid,
    input logic                    dut_out,
    input logic signed [SIG_W-1:0] sig_dc,
    input logic signed [SIG_W-1:0] sig_par
);
    localparam logic signed [SIG_W-1:0] MAX_V = {1'b0, {(SIG_W-1){1'b1}}};
    localparam logic signed [SIG_W-1:0] MIN_V = {1'b1, {(SIG_W-1){1'b0}}};
    localparam logic signed [SIG_W-1:0] ONE_V = {{(SIG_W-1){1'b0}}, 1'b1};

    logic armed = 1'b0;

    // Marks that at least one clock edge has been seen.
    always_ff @(posedge clk) armed <= 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        !$past(rst_n) |-> (sig_dc == '0 && sig_par == '0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n) && !$past(run && vec_valid)) |-> ($stable(sig_dc) && $stable(sig_par)));

    // R3
    dc_up_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(rst_n && run && vec_valid && dut_out)
        |-> (sig_dc == $past(sig_dc) + ONE_V || ($past(sig_dc) == MAX_V && sig_dc == MAX_V)));

    // R3
    dc_down_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(rst_n && run && vec_valid && !dut_out)
        |-> (sig_dc == $past(sig_dc) - ONE_V || ($past(sig_dc) == MIN_V && sig_dc == MIN_V)));

    // R5
    no_wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n) && $past(sig_par) == MAX_V) |-> sig_par != MIN_V);

    // R6
    no_wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n) && $past(sig_par) == MIN_V) |-> sig_par != MAX_V);

    // R7
    par_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(rst_n && run && vec_valid)
        |-> (sig_par == $past(sig_par) + ONE_V || sig_par == $past(sig_par) - ONE_V
             || (sig_par == $past(sig_par) && (sig_par == MAX_V || sig_par == MIN_V))));
endmodule

bind walsh_sig_compactor walsh_sig_compactor_chk #(.SIG_W(SIG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .vec_valid (vec_valid),
    .dut_out   (dut_out),
    .sig_dc    (sig_dc),
    .sig_par   (sig_par)
);

// File: tb/walsh_sig_compactor_test.sv
// Self-checking bench for walsh_sig_compactor, run at a narrow width.
module walsh_sig_compactor_test;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 4;
    localparam int SW = 5;
    localparam int N_TBL = 8;
    // Stimulus: {run, vec_valid, vec[3:0], dut_out}
    localparam logic [6:0] STIM [N_TBL] = '{
        7'b11_0000_1, 7'b11_0001_1, 7'b11_0011_0, 7'b01_1111_1,
        7'b10_1111_1, 7'b11_0111_0, 7'b11_1111_1, 7'b11_1110_0
    };
    localparam int EXP_DC  [N_TBL] = '{1, 2, 1, 1, 1, 0, 1, 0};
    localparam int EXP_PAR [N_TBL] = '{1, 0, -1, -1, -1, 0, 1, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic vec_valid = 1'b0;
    logic [VW-1:0] vec = '0;
    logic dut_out = 1'b0;
    logic signed [SW-1:0] sig_dc;
    logic signed [SW-1:0] sig_par;
    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    walsh_sig_compactor #(.VEC_W(VW), .SIG_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .vec_valid(vec_valid),
        .vec(vec), .dut_out(dut_out), .sig_dc(sig_dc), .sig_par(sig_par)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [VW-1:0] x, input logic o);
        run = r; vec_valid = v; vec = x; dut_out = o;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1'b1, 1'b1, 4'b0000, 1'b1);
        check("R1 reset dc", int'(sig_dc), 0);
        check("R1 reset par", int'(sig_par), 0);
        rst_n = 1'b1;
        for (int i = 0; i < N_TBL; i++) begin
            step(STIM[i][6], STIM[i][5], STIM[i][4:1], STIM[i][0]);
            check("R2/R3 table dc", int'(sig_dc), EXP_DC[i]);
            check("R2/R4 table par", int'(sig_par), EXP_PAR[i]);
        end
        // R8: not visible before the sampling edge, visible right after it
        run = 1'b1; vec_valid = 1'b1; vec = 4'b0000; dut_out = 1'b1;
        #(CLK_PERIOD/2 - 1);
        check("R8 before edge dc", int'(sig_dc), 0);
        check("R8 before edge par", int'(sig_par), 2);
        #(CLK_PERIOD/2 + 1);
        check("R8 after edge dc", int'(sig_dc), 1);
        check("R8 after edge par", int'(sig_par), 3);
        @(negedge clk);
        // R5: drive past the upper limit
        for (int i = 0; i < 19; i++) step(1'b1, 1'b1, 4'b0000, 1'b1);
        check("R5 high limit dc", int'(sig_dc), 15);
        check("R5 high limit par", int'(sig_par), 15);
        // R2: stopped with changing inputs
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 4'(i), i[0]);
        check("R2 stopped dc", int'(sig_dc), 15);
        check("R2 stopped par", int'(sig_par), 15);
        // R6: drive past the lower limit
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 4'b0000, 1'b0);
        check("R6 low limit dc", int'(sig_dc), -16);
        check("R6 low limit par", int'(sig_par), -16);
        // R6/R4/R7: DC held at limit while parity agrees and climbs one
        step(1'b1, 1'b1, 4'b0001, 1'b0);
        check("R6 dc held", int'(sig_dc), -16);
        check("R7 par one step", int'(sig_par), -15);
        // R1: reset wins over an active update
        rst_n = 1'b0;
        step(1'b1, 1'b1, 4'b0000, 1'b1);
        check("R1 mid-run reset dc", int'(sig_dc), 0);
        check("R1 mid-run reset par", int'(sig_par), 0);
        rst_n = 1'b1;
        // R4: three zeros (odd), reference 0, response 1 disagrees
        step(1'b1, 1'b1, 4'b0001, 1'b1);
        check("R3 after reset dc", int'(sig_dc), 1);
        check("R4 odd zeros par", int'(sig_par), -1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule